// File: doc/BRIEF.md
# Shader Dual/Co-Issue Pairing Checker

This block sits in front of a two-stage pixel shader arithmetic pipe and decides, once per cycle, which of up to four decoded candidate operations may issue together. The first stage holds a special-function unit, four multiply lanes and a texture address path. The second stage holds adders, multipliers and a second special-function unit. Each stage has a four-channel lane budget. A stage can be used whole, split as three plus one channels, or split as two plus two. Which operations may pair depends on what each stage can execute, on that lane budget, and on data dependences inside the group. Two same-cycle forwarding paths are allowed inside the first stage.

Candidates are examined in program order. Each one goes to the first stage if it legally can, otherwise to the second stage. The first candidate that fits neither stage is held, together with every candidate after it. The upstream decoder re-presents the held candidates on the next cycle. The decisions are registered and handed to the datapath through a valid/ready pair. For each cycle the outputs give: which candidates were accepted, which stage each one went to, which candidate owns each lane of each stage, a split code per stage, and a stall flag.

Top module: `shader_pair_top`

## Requirements
- R1: Class codes are PASS=0, MUL=1, ADD=2, MAD=3, RCP=4, RSQ=5, TEX=6. ADD and MAD are never placed in the first stage, and TEX is never placed in the second stage. RCP, RSQ, MUL and PASS may go to either stage.
- R2: Each candidate is placed in the first stage when that is legal, and in the second stage otherwise. Stage codes per candidate (two bits, candidate k at bits 2k+1:2k) are 0 for not issued, 1 for first stage and 2 for second stage.
- R3: Each stage has four lanes. RCP and RSQ cost one lane. Every other class costs the popcount of its four-bit write mask. A candidate whose cost would push its stage past four lanes does not go to that stage. For example, a 2-component MUL and a 3-component MUL never share the first stage.
- R4: A stage accepts at most two operations per cycle, and at most one RCP/RSQ. The first stage accepts at most one TEX. Once a TEX is in the first stage, no further MUL joins that stage.
- R5: A TEX that reads the destination of a MUL already placed in the first stage may join the first stage in the same cycle, and it costs no extra lanes. This is the only case in which TEX sidesteps the dependence rule.
- R6: A MUL that reads the destination of an RCP/RSQ already placed in the first stage may join the first stage in the same cycle. If the special function sits in the second stage, the MUL is held.
- R7: Apart from R5 and R6, a candidate whose source register equals the destination of any earlier candidate in the group is not placed in this group.
- R8: A PASS candidate only enters an empty stage. That stage then accepts nothing else for the cycle.
- R9: The first candidate, among the presented count, that fits no stage is held together with all later candidates. The accept vector is therefore a contiguous run from candidate 0. Stall is 1 exactly when some presented candidate was held.
- R10: Lane owner maps give each stage's lanes, lane l at bits 3l+2:3l, as 0 for a free lane or k+1 for candidate k. Lanes are handed out from lane 0 upward in program order.
- R11: Split code per stage is 0 for empty and 1 for one operation. With two operations it is 2 when the smaller lane cost is at most one, and 3 otherwise.
- R12: Outputs change only on a clock edge that accepts a new group. While the output is valid and the datapath is not ready, the outputs hold and the block is not ready for input.
- R13: A synchronous active-high reset clears output valid, the accept vector, stall, stage codes, lane maps and split codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A candidate group is presented |
| inReady | output | 1 | Block can take a group this cycle |
| candCount | input | 3 | Number of presented candidates, 0 to 4 |
| candClass | input | 12 | Class code per candidate, 3 bits each |
| candMask | input | 16 | Write mask per candidate, 4 bits each |
| candDst | input | 16 | Destination register per candidate |
| candSrcA | input | 16 | First source register per candidate |
| candSrcB | input | 16 | Second source register per candidate |
| outReady | input | 1 | Datapath accepts the registered decision |
| outValid | output | 1 | Registered decision is valid |
| acceptVec | output | 4 | Candidates issued this group |
| opStage | output | 8 | Stage code per candidate |
| laneOwnA | output | 12 | First-stage lane owner map |
| laneOwnB | output | 12 | Second-stage lane owner map |
| splitA | output | 2 | First-stage split code |
| splitB | output | 2 | Second-stage split code |
| stall | output | 1 | Some presented candidate was held |

## Verification
The assertions assume two things whenever inValid is high: every presented class code lies in 0 to 6, and candCount is at most four. The placement properties are evaluated only in cycles where inValid is high. The stimulus meets both assumptions by construction. Random classes are taken modulo seven and counts are drawn from one to four. Register indices come from a small pool, so dependences and forwarding cases occur often.

// File: rtl/shader_pair_pkg.sv
package shader_pair_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_MUL  = 3'd1,
    OP_ADD  = 3'd2,
    OP_MAD  = 3'd3,
    OP_RCP  = 3'd4,
    OP_RSQ  = 3'd5,
    OP_TEX  = 3'd6
  } opClass_e;

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } opStage_e;

  typedef enum logic [1:0] {
    SPL_IDLE  = 2'd0,
    SPL_WHOLE = 2'd1,
    SPL_V3S   = 2'd2,
    SPL_V2V2  = 2'd3
  } split_e;

  typedef struct packed {
    logic load;
    logic drain;
  } pairStrobe_t;

endpackage

// File: rtl/shader_pair_plan.sv
module shader_pair_plan
  import shader_pair_pkg::*;
#(
  parameter int NUM_OPS     = 4,
  parameter int NUM_LANES   = 4,
  parameter int REG_W       = 4,
  parameter int STAGE_SLOTS = 2,
  localparam int CNT_W      = $clog2(NUM_OPS + 1),
  localparam int OWN_W      = $clog2(NUM_OPS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [CNT_W-1:0]             candCount,
  input  logic [NUM_OPS*3-1:0]         candClass,
  input  logic [NUM_OPS*NUM_LANES-1:0] candMask,
  input  logic [NUM_OPS*REG_W-1:0]     candDst,
  input  logic [NUM_OPS*REG_W-1:0]     candSrcA,
  input  logic [NUM_OPS*REG_W-1:0]     candSrcB,
  output logic [NUM_OPS-1:0]           planAccept,
  output logic [NUM_OPS*2-1:0]         planStage,
  output logic [NUM_LANES*OWN_W-1:0]   planOwnA,
  output logic [NUM_LANES*OWN_W-1:0]   planOwnB,
  output split_e                       planSplitA,
  output split_e                       planSplitB,
  output logic                         planHold
);

  always_comb begin
    opStage_e stg [NUM_OPS];
    opClass_e cls, clsJ;
    logic blocked, isSfu, rd, hitAny, hitOdd, fwd, canA, canB, sfuFwd, texFwd;
    logic sfuA, sfuB, texA, busyA, busyB;
    int laneA, laneB, opsA, opsB, minA, minB, cost, effA;
    planOwnA = '0;
    planOwnB = '0;
    planAccept = '0;
    planStage = '0;
    planHold = 1'b0;
    blocked = 1'b0;
    sfuA = 1'b0; sfuB = 1'b0; texA = 1'b0; busyA = 1'b0; busyB = 1'b0;
    laneA = 0; laneB = 0; opsA = 0; opsB = 0;
    minA = NUM_LANES; minB = NUM_LANES;
    for (int k = 0; k < NUM_OPS; k++) stg[k] = ST_NONE;
    for (int i = 0; i < NUM_OPS; i++) begin
      cls = opClass_e'(candClass[i*3 +: 3]);
      isSfu = (cls == OP_RCP) || (cls == OP_RSQ);
      cost = isSfu ? 1 : $countones(candMask[i*NUM_LANES +: NUM_LANES]);
      hitAny = 1'b0; hitOdd = 1'b0; fwd = 1'b0;
      for (int j = 0; j < NUM_OPS; j++) begin
        if (j < i) begin
          clsJ = opClass_e'(candClass[j*3 +: 3]);
          rd = (candSrcA[i*REG_W +: REG_W] == candDst[j*REG_W +: REG_W]) ||
               (candSrcB[i*REG_W +: REG_W] == candDst[j*REG_W +: REG_W]);
          sfuFwd = (cls == OP_MUL) && (stg[j] == ST_FIRST) &&
                   ((clsJ == OP_RCP) || (clsJ == OP_RSQ));
          texFwd = (cls == OP_TEX) && (stg[j] == ST_FIRST) && (clsJ == OP_MUL);
          if (rd) begin
            hitAny = 1'b1;
            if (texFwd) fwd = 1'b1;
            if (!sfuFwd && !texFwd) hitOdd = 1'b1;
          end
        end
      end
      effA = ((cls == OP_TEX) && fwd) ? 0 : cost;
      case (cls)
        OP_MUL:         canA = !texA;
        OP_RCP, OP_RSQ: canA = !sfuA;
        OP_TEX:         canA = !texA;
        OP_PASS:        canA = (opsA == 0);
        default:        canA = 1'b0;
      endcase
      canA = canA && !busyA && (opsA < STAGE_SLOTS) && !hitOdd && (laneA + effA <= NUM_LANES);
      case (cls)
        OP_MUL, OP_ADD, OP_MAD: canB = 1'b1;
        OP_RCP, OP_RSQ:         canB = !sfuB;
        OP_PASS:                canB = (opsB == 0);
        default:                canB = 1'b0;
      endcase
      canB = canB && !busyB && (opsB < STAGE_SLOTS) && !hitAny && (laneB + cost <= NUM_LANES);
      if ((i < int'(candCount)) && !blocked) begin
        if (canA) begin
          stg[i] = ST_FIRST;
          for (int l = 0; l < NUM_LANES; l++)
            if ((l >= laneA) && (l < laneA + effA)) planOwnA[l*OWN_W +: OWN_W] = OWN_W'(i + 1);
          laneA = laneA + effA;
          opsA = opsA + 1;
          if (effA < minA) minA = effA;
          sfuA = sfuA || isSfu;
          texA = texA || (cls == OP_TEX);
          busyA = busyA || (cls == OP_PASS);
        end else if (canB) begin
          stg[i] = ST_SECOND;
          for (int l = 0; l < NUM_LANES; l++)
            if ((l >= laneB) && (l < laneB + cost)) planOwnB[l*OWN_W +: OWN_W] = OWN_W'(i + 1);
          laneB = laneB + cost;
          opsB = opsB + 1;
          if (cost < minB) minB = cost;
          sfuB = sfuB || isSfu;
          busyB = busyB || (cls == OP_PASS);
        end else begin
          blocked = 1'b1;
          planHold = 1'b1;
        end
      end
      planAccept[i] = (stg[i] != ST_NONE);
      planStage[i*2 +: 2] = stg[i];
    end
    planSplitA = (opsA == 0) ? SPL_IDLE : (opsA == 1) ? SPL_WHOLE : (minA <= 1) ? SPL_V3S : SPL_V2V2;
    planSplitB = (opsB == 0) ? SPL_IDLE : (opsB == 1) ? SPL_WHOLE : (minB <= 1) ? SPL_V3S : SPL_V2V2;
  end

  logic [NUM_OPS-1:0] inFirst;
  logic [NUM_OPS-1:0] inSecond;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gChk
    assign inFirst[g]  = (planStage[g*2 +: 2] == ST_FIRST);
    assign inSecond[g] = (planStage[g*2 +: 2] == ST_SECOND);
    AST_ADD_NOT_FIRST: assert property (@(posedge clk) disable iff (rst)
      inValid && ((candClass[g*3 +: 3] == OP_ADD) || (candClass[g*3 +: 3] == OP_MAD)) |-> !inFirst[g]); // R1
    AST_TEX_NOT_SECOND: assert property (@(posedge clk) disable iff (rst)
      inValid && (candClass[g*3 +: 3] == OP_TEX) |-> !inSecond[g]); // R1
  end

  AST_STAGE_SLOTS: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ($countones(inFirst) <= STAGE_SLOTS) && ($countones(inSecond) <= STAGE_SLOTS)); // R4
  AST_ACCEPT_PREFIX: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ((planAccept & (planAccept + 1'b1)) == '0)); // R9
  AST_HOLD_GAP: assert property (@(posedge clk) disable iff (rst)
    inValid && planHold |-> ($countones(planAccept) < int'(candCount))); // R9

endmodule

// File: rtl/shader_pair_ctrl.sv
module shader_pair_ctrl
  import shader_pair_pkg::*;
(
  input  logic        inValid,
  input  logic        outValid,
  input  logic        outReady,
  output logic        inReady,
  output pairStrobe_t strobe
);

  always_comb begin
    inReady = !outValid || outReady;
    strobe.load = inValid && inReady;
    strobe.drain = outValid && outReady && !strobe.load;
  end

endmodule

// File: rtl/shader_pair_regs.sv
module shader_pair_regs
  import shader_pair_pkg::*;
#(
  parameter int NUM_OPS   = 4,
  parameter int NUM_LANES = 4,
  localparam int OWN_W    = $clog2(NUM_OPS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pairStrobe_t                strobe,
  input  logic [NUM_OPS-1:0]         planAccept,
  input  logic [NUM_OPS*2-1:0]       planStage,
  input  logic [NUM_LANES*OWN_W-1:0] planOwnA,
  input  logic [NUM_LANES*OWN_W-1:0] planOwnB,
  input  split_e                     planSplitA,
  input  split_e                     planSplitB,
  input  logic                       planHold,
  output logic                       outValid,
  output logic [NUM_OPS-1:0]         acceptVec,
  output logic [NUM_OPS*2-1:0]       opStage,
  output logic [NUM_LANES*OWN_W-1:0] laneOwnA,
  output logic [NUM_LANES*OWN_W-1:0] laneOwnB,
  output split_e                     splitA,
  output split_e                     splitB,
  output logic                       stall
);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      acceptVec <= '0;
      opStage   <= '0;
      laneOwnA  <= '0;
      laneOwnB  <= '0;
      splitA    <= SPL_IDLE;
      splitB    <= SPL_IDLE;
      stall     <= 1'b0;
    end else if (strobe.load) begin
      outValid  <= 1'b1;
      acceptVec <= planAccept;
      opStage   <= planStage;
      laneOwnA  <= planOwnA;
      laneOwnB  <= planOwnB;
      splitA    <= planSplitA;
      splitB    <= planSplitB;
      stall     <= planHold;
    end else if (strobe.drain) begin
      outValid  <= 1'b0;
    end
  end

endmodule

// File: rtl/shader_pair_top.sv
module shader_pair_top
  import shader_pair_pkg::*;
#(
  parameter int NUM_OPS     = 4,
  parameter int NUM_LANES   = 4,
  parameter int REG_W       = 4,
  parameter int STAGE_SLOTS = 2,
  localparam int CNT_W      = $clog2(NUM_OPS + 1),
  localparam int OWN_W      = $clog2(NUM_OPS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [CNT_W-1:0]             candCount,
  input  logic [NUM_OPS*3-1:0]         candClass,
  input  logic [NUM_OPS*NUM_LANES-1:0] candMask,
  input  logic [NUM_OPS*REG_W-1:0]     candDst,
  input  logic [NUM_OPS*REG_W-1:0]     candSrcA,
  input  logic [NUM_OPS*REG_W-1:0]     candSrcB,
  input  logic                         outReady,
  output logic                         outValid,
  output logic [NUM_OPS-1:0]           acceptVec,
  output logic [NUM_OPS*2-1:0]         opStage,
  output logic [NUM_LANES*OWN_W-1:0]   laneOwnA,
  output logic [NUM_LANES*OWN_W-1:0]   laneOwnB,
  output logic [1:0]                   splitA,
  output logic [1:0]                   splitB,
  output logic                         stall
);

  logic [NUM_OPS-1:0]         planAccept;
  logic [NUM_OPS*2-1:0]       planStage;
  logic [NUM_LANES*OWN_W-1:0] planOwnA, planOwnB;
  split_e                     planSplitA, planSplitB, regSplitA, regSplitB;
  logic                       planHold;
  pairStrobe_t                strobe;

  shader_pair_plan #(.NUM_OPS(NUM_OPS), .NUM_LANES(NUM_LANES), .REG_W(REG_W),
                     .STAGE_SLOTS(STAGE_SLOTS)) uPlan (
    .clk(clk), .rst(rst), .inValid(inValid), .candCount(candCount),
    .candClass(candClass), .candMask(candMask), .candDst(candDst),
    .candSrcA(candSrcA), .candSrcB(candSrcB), .planAccept(planAccept),
    .planStage(planStage), .planOwnA(planOwnA), .planOwnB(planOwnB),
    .planSplitA(planSplitA), .planSplitB(planSplitB), .planHold(planHold));

  shader_pair_ctrl uCtrl (
    .inValid(inValid), .outValid(outValid), .outReady(outReady),
    .inReady(inReady), .strobe(strobe));

  shader_pair_regs #(.NUM_OPS(NUM_OPS), .NUM_LANES(NUM_LANES)) uRegs (
    .clk(clk), .rst(rst), .strobe(strobe), .planAccept(planAccept),
    .planStage(planStage), .planOwnA(planOwnA), .planOwnB(planOwnB),
    .planSplitA(planSplitA), .planSplitB(planSplitB), .planHold(planHold),
    .outValid(outValid), .acceptVec(acceptVec), .opStage(opStage),
    .laneOwnA(laneOwnA), .laneOwnB(laneOwnB), .splitA(regSplitA),
    .splitB(regSplitB), .stall(stall));

  assign splitA = regSplitA;
  assign splitB = regSplitB;

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(acceptVec) && $stable(opStage) && $stable(stall)); // R12
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady); // R12

endmodule

// File: tb/tb_shader_pair_top.sv
`timescale 1ns/1ps
module tb_shader_pair_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  candCount = '0;
  logic [11:0] candClass = '0;
  logic [15:0] candMask = '0;
  logic [15:0] candDst = '0;
  logic [15:0] candSrcA = '0;
  logic [15:0] candSrcB = '0;
  logic        outReady = 1'b1;
  logic        outValid;
  logic [3:0]  acceptVec;
  logic [7:0]  opStage;
  logic [11:0] laneOwnA, laneOwnB;
  logic [1:0]  splitA, splitB;
  logic        stall;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  int gCls [4];
  int gMask [4];
  int gDst [4];
  int gSa [4];
  int gSb [4];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  shader_pair_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .candCount(candCount), .candClass(candClass), .candMask(candMask),
    .candDst(candDst), .candSrcA(candSrcA), .candSrcB(candSrcB),
    .outReady(outReady), .outValid(outValid), .acceptVec(acceptVec),
    .opStage(opStage), .laneOwnA(laneOwnA), .laneOwnB(laneOwnB),
    .splitA(splitA), .splitB(splitB), .stall(stall));

  task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  function automatic int unsigned nextRand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic setOp(input int k, input int c, input int m, input int d, input int a, input int b);
    gCls[k] = c; gMask[k] = m; gDst[k] = d; gSa[k] = a; gSb[k] = b;
  endtask

  task automatic clearOps();
    for (int k = 0; k < 4; k++) setOp(k, 1, 0, 12 + k, 8, 9);
  endtask

  task automatic loadPins(input int n);
    candCount = 3'(n);
    for (int k = 0; k < 4; k++) begin
      candClass[k*3 +: 3] = 3'(gCls[k]);
      candMask[k*4 +: 4]  = 4'(gMask[k]);
      candDst[k*4 +: 4]   = 4'(gDst[k]);
      candSrcA[k*4 +: 4]  = 4'(gSa[k]);
      candSrcB[k*4 +: 4]  = 4'(gSb[k]);
    end
  endtask

  // Present one group with the datapath ready; return at the negedge after the capturing edge.
  task automatic present(input int n);
    @(negedge clk);
    loadPins(n);
    inValid = 1'b1;
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Reference placement written from the requirement text.
  task automatic model(input int n, output int eAcc, output int eStg, output int eOwnA,
                       output int eOwnB, output int eSpA, output int eSpB, output int eStall);
    int stg [4];
    int laneA, laneB, opsA, opsB, minA, minB;
    bit sfuA, sfuB, texA, busyA, busyB, blocked;
    laneA = 0; laneB = 0; opsA = 0; opsB = 0; minA = 4; minB = 4;
    sfuA = 0; sfuB = 0; texA = 0; busyA = 0; busyB = 0; blocked = 0;
    eAcc = 0; eStg = 0; eOwnA = 0; eOwnB = 0; eStall = 0;
    for (int i = 0; i < 4; i++) stg[i] = 0;
    for (int i = 0; i < n; i++) begin
      bit sfu, hitAny, hitOdd, fwd, okA, okB;
      int cost, effA;
      if (blocked) break;
      sfu = (gCls[i] == 4) || (gCls[i] == 5);
      cost = sfu ? 1 : $countones(4'(gMask[i]));
      hitAny = 0; hitOdd = 0; fwd = 0;
      for (int j = 0; j < i; j++) begin
        if (gSa[i] == gDst[j] || gSb[i] == gDst[j]) begin
          hitAny = 1;
          if (gCls[i] == 6 && stg[j] == 1 && gCls[j] == 1) fwd = 1;
          else if (!(gCls[i] == 1 && stg[j] == 1 && (gCls[j] == 4 || gCls[j] == 5))) hitOdd = 1;
        end
      end
      effA = (gCls[i] == 6 && fwd) ? 0 : cost;
      okA = !busyA && opsA < 2 && !hitOdd && laneA + effA <= 4 &&
            ((gCls[i] == 1 && !texA) || (sfu && !sfuA) || (gCls[i] == 6 && !texA) ||
             (gCls[i] == 0 && opsA == 0));
      okB = !busyB && opsB < 2 && !hitAny && laneB + cost <= 4 &&
            (gCls[i] == 1 || gCls[i] == 2 || gCls[i] == 3 || (sfu && !sfuB) ||
             (gCls[i] == 0 && opsB == 0));
      if (okA) begin
        stg[i] = 1;
        for (int l = laneA; l < laneA + effA; l++) eOwnA |= (i + 1) << (3 * l);
        laneA += effA; opsA++; if (effA < minA) minA = effA;
        if (sfu) sfuA = 1;
        if (gCls[i] == 6) texA = 1;
        if (gCls[i] == 0) busyA = 1;
      end else if (okB) begin
        stg[i] = 2;
        for (int l = laneB; l < laneB + cost; l++) eOwnB |= (i + 1) << (3 * l);
        laneB += cost; opsB++; if (cost < minB) minB = cost;
        if (sfu) sfuB = 1;
        if (gCls[i] == 0) busyB = 1;
      end else begin
        blocked = 1;
        eStall = 1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (stg[i] != 0) eAcc |= 1 << i;
      eStg |= stg[i] << (2 * i);
    end
    eSpA = (opsA == 0) ? 0 : (opsA == 1) ? 1 : (minA <= 1) ? 2 : 3;
    eSpB = (opsB == 0) ? 0 : (opsB == 1) ? 1 : (minB <= 1) ? 2 : 3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired before the sequence finished");
      summary();
      $finish;
    end
  end

  initial begin
    int eAcc, eStg, eOwnA, eOwnB, eSpA, eSpB, eStall;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk("R13", outValid == 0, "outValid after reset", outValid, 0);
    chk("R13", acceptVec == 0 && stall == 0, "accept/stall after reset", {acceptVec, stall}, 0);
    chk("R13", opStage == 0 && laneOwnA == 0 && splitA == 0, "stage/lane/split after reset", opStage, 0);
    chk("R12", inReady == 1, "inReady when empty", inReady, 1);

    // R1: ADD and MAD go to the second stage, TEX to the first
    clearOps();
    setOp(0, 2, 4'b0001, 1, 8, 9); setOp(1, 3, 4'b0001, 2, 8, 9); setOp(2, 6, 4'b0011, 3, 8, 9);
    present(3);
    chk("R1", opStage == 8'd26, "stage codes ADD/MAD/TEX", opStage, 26);
    chk("R1", acceptVec == 4'b0111, "accept ADD/MAD/TEX", acceptVec, 7);

    // R2: four scalar MULs fill the first stage then the second
    clearOps();
    for (int k = 0; k < 4; k++) setOp(k, 1, 4'b0001, 1 + k, 8, 9);
    present(4);
    chk("R2", opStage == 8'd165, "four MUL stage codes", opStage, 165);
    chk("R11", splitA == 2 && splitB == 2, "split codes for 1+1", {splitA, splitB}, 10);
    chk("R9", stall == 0, "no stall when all placed", stall, 0);

    // R3: MUL2 and MUL3 cannot share the first stage
    clearOps();
    setOp(0, 1, 4'b0011, 1, 8, 9); setOp(1, 1, 4'b0111, 2, 8, 9);
    present(2);
    chk("R3", opStage == 8'd9, "MUL2+MUL3 split across stages", opStage, 9);
    chk("R11", splitA == 1 && splitB == 1, "whole split each stage", {splitA, splitB}, 5);

    // R3/R11: MUL2 and MUL2 share the first stage as two plus two
    clearOps();
    setOp(0, 1, 4'b0011, 1, 8, 9); setOp(1, 1, 4'b1100, 2, 8, 9);
    present(2);
    chk("R3", opStage == 8'd5, "MUL2+MUL2 both first stage", opStage, 5);
    chk("R11", splitA == 3, "two-plus-two split code", splitA, 3);

    // R10/R11: a single vec4 MUL owns all first-stage lanes
    clearOps();
    setOp(0, 1, 4'b1111, 1, 8, 9);
    present(1);
    chk("R10", laneOwnA == 12'd585, "vec4 lane owners", laneOwnA, 585);
    chk("R11", splitA == 1 && splitB == 0, "whole/idle split", {splitA, splitB}, 4);

    // R4: a third special function finds no free unit
    clearOps();
    setOp(0, 4, 4'b0001, 1, 8, 9); setOp(1, 5, 4'b0001, 2, 8, 9); setOp(2, 4, 4'b0001, 3, 8, 9);
    present(3);
    chk("R4", acceptVec == 4'b0011, "one SFU per stage", acceptVec, 3);
    chk("R9", stall == 1, "stall on held SFU", stall, 1);

    // R5: TEX forwarded from a first-stage MUL costs no lanes
    clearOps();
    setOp(0, 1, 4'b0011, 5, 8, 9); setOp(1, 6, 4'b0011, 6, 5, 9); setOp(2, 1, 4'b0001, 7, 8, 9);
    present(3);
    chk("R5", opStage == 8'd37, "MUL->TEX co-issue", opStage, 37);
    chk("R5", laneOwnA == 12'd9, "TEX adds no lanes", laneOwnA, 9);
    chk("R11", splitA == 2, "split with forwarded TEX", splitA, 2);

    // R7: TEX depending on a second-stage ADD is held
    clearOps();
    setOp(0, 2, 4'b0001, 5, 8, 9); setOp(1, 6, 4'b0011, 6, 5, 9);
    present(2);
    chk("R7", acceptVec == 4'b0001 && stall == 1, "TEX after ADD held", {acceptVec, stall}, 3);

    // R6/R10: SFU feeds a MUL inside the first stage
    clearOps();
    setOp(0, 4, 4'b0001, 3, 8, 9); setOp(1, 1, 4'b0111, 4, 3, 9);
    present(2);
    chk("R6", opStage == 8'd5, "SFU->MUL co-issue", opStage, 5);
    chk("R10", laneOwnA == 12'd1169, "SFU+MUL3 lane owners", laneOwnA, 1169);

    // R6: SFU result in the second stage cannot feed a MUL this cycle
    clearOps();
    setOp(0, 4, 4'b0001, 1, 8, 9); setOp(1, 5, 4'b0001, 3, 8, 9); setOp(2, 1, 4'b0001, 4, 3, 9);
    present(3);
    chk("R6", acceptVec == 4'b0011 && stall == 1, "MUL after second-stage SFU held", {acceptVec, stall}, 7);

    // R7: dependence on an ADD blocks co-issue
    clearOps();
    setOp(0, 2, 4'b0001, 4, 8, 9); setOp(1, 1, 4'b0001, 5, 4, 9);
    present(2);
    chk("R7", acceptVec == 4'b0001 && stall == 1, "MUL after ADD held", {acceptVec, stall}, 3);

    // R8: PASS makes the first stage busy
    clearOps();
    setOp(0, 0, 4'b0001, 1, 8, 9);
    for (int k = 1; k < 4; k++) setOp(k, 1, 4'b0001, 1 + k, 8, 9);
    present(4);
    chk("R8", opStage == 8'd41, "PASS then MULs", opStage, 41);
    chk("R9", acceptVec == 4'b0111 && stall == 1, "fourth held after PASS", {acceptVec, stall}, 15);

    // R12: outputs hold while the datapath is not ready
    clearOps();
    setOp(0, 4, 4'b0001, 1, 8, 9); setOp(1, 5, 4'b0001, 2, 8, 9); setOp(2, 4, 4'b0001, 3, 8, 9);
    @(negedge clk);
    loadPins(3); inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    clearOps(); setOp(0, 1, 4'b1111, 1, 8, 9);
    loadPins(1);
    chk("R12", inReady == 0, "not ready while output pending", inReady, 0);
    @(negedge clk);
    chk("R12", outValid == 1 && acceptVec == 4'b0011, "output held", {outValid, acceptVec}, 19);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R12", acceptVec == 4'b0001 && stall == 0, "next group taken on ready", {acceptVec, stall}, 2);
    @(negedge clk);
    chk("R12", outValid == 0, "drained", outValid, 0);

    // Sweep against the reference placement
    for (int t = 0; t < 3000; t++) begin
      int n;
      n = 1 + int'(nextRand() % 4);
      for (int k = 0; k < 4; k++)
        setOp(k, int'(nextRand() % 7), int'(nextRand() % 16), int'(nextRand() % 4),
              int'(nextRand() % 6), int'(nextRand() % 6));
      model(n, eAcc, eStg, eOwnA, eOwnB, eSpA, eSpB, eStall);
      present(n);
      chk("R2", int'(acceptVec) == eAcc && int'(opStage) == eStg, "sweep stage codes", opStage, eStg);
      chk("R10", int'(laneOwnA) == eOwnA && int'(laneOwnB) == eOwnB, "sweep lane owners A", laneOwnA, eOwnA);
      chk("R11", int'(splitA) == eSpA && int'(splitB) == eSpB, "sweep split codes", {splitA, splitB}, eSpA * 4 + eSpB);
      chk("R9", int'(stall) == eStall, "sweep stall", stall, eStall);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule